// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Load/Advance Sequencer

This block is a synthesizable behavioural model of a synchronous static RAM whose read data flows straight from the array to the output in the cycle after the address is registered, with no output register. Writes take their data one enabled clock after the address, so a write can be followed at once by a read, or a read by a write, with no idle cycle between them. All inputs except the output enable are sampled on the rising clock edge. A clock-enable input (active low) can freeze the whole device for any number of edges.

An access starts when the device is selected by three chip enables and the load/advance control is low. The write-enable level at that edge fixes the direction of the access. Later edges with load/advance high step a two-bit burst counter over the two low address bits, in a linear or an interleaved order chosen by a mode input. The burst keeps the direction it started with. Byte-lane write strobes pick which lanes of a word a write updates. The tri-state output is modelled as a separate data-out bus plus a valid flag.

Top module: `fbsram_top`

## Requirements
- R1: When `clk_en_n` is high at a rising edge, that edge is ignored: the burst state, the direction, the array contents and the output state are all unchanged.
- R2: A new access is loaded at an edge with `clk_en_n` low, `ld_n` low and the device selected (`cs1_n` low, `cs2` high, `cs3_n` low). `wr_n` low at that edge makes it a write and `wr_n` high makes it a read.
- R3: Write data `din` and lane strobes `lane_n` are taken at the next enabled edge after the edge that registered the write address. Lane i is bits [8i+7:8i], and it is written only when `lane_n[i]` is low. Other lanes keep their old value.
- R4: Read data for a registered read address appears on `dout` with `dout_vld` high in the cycle right after the edge. `oe_n` high forces `dout_vld` low with no clock involved.
- R5: An enabled edge with `ld_n` low and the device not selected ends any access. From the following cycle `dout_vld` is low.
- R6: An enabled edge with `ld_n` high during an access moves to the next burst beat. This happens whatever the chip enables or `wr_n` are doing, and the direction set at load is kept.
- R7: With `ilv_mode` low at load, the low two address bits step linearly modulo 4 from the loaded start (start 1 gives 1,2,3,0). Bits above them stay fixed.
- R8: With `ilv_mode` high at load, the low two bits are the start XOR the beat number 0,1,2,3. The mode is sampled only at the load edge.
- R9: An advance (`ld_n` high) while no access is active is ignored. No burst restarts and `dout_vld` stays low.
- R10: A read loaded at the same edge that takes the data of a write returns the newly written word in the next cycle.
- R11: While `rst` is high, no access is active, `dout_vld` is low and the array is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| clk_en_n | input | 1 | Clock qualifier, low enables the edge |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| ld_n | input | 1 | Low loads a new address, high advances the burst |
| wr_n | input | 1 | Direction at load: low write, high read |
| lane_n | input | NB | Per-byte write strobes, active low |
| ilv_mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| din | input | NB*8 | Write data |
| dout | output | NB*8 | Read data, zero when not valid |
| dout_vld | output | 1 | Output driven (stands in for tri-state) |

## Verification
The bench targets bursts that start in mid-block in both orders. A sequencer with the wrong order or a missing wrap would return the words in the wrong sequence. Stalls with the clock enable high are placed in the middle of bursts and at the write-data edge; a design that leaked an edge would skip a beat or commit a write early. Advances are issued with the chip enables off and after a deselect, which exposes a design that gates the counter with the selects or revives a finished burst. Partial-lane writes and a read right behind a write to the same word catch lane-merge mistakes and stale data.

// File: rtl/fbsram_pkg.sv
package fbsram_pkg;

    localparam int unsigned LANE_W = 8;

    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } dir_e;

    typedef struct packed {
        logic       active;
        dir_e       dir;
        logic       ilv;
        logic [1:0] start;
        logic [1:0] beat;
    } burst_st_t;

    function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                            input logic [1:0] beat,
                                            input logic       ilv);
        logic [1:0] r;
        if (ilv) r = start ^ beat;
        else     r = start + beat;
        return r;
    endfunction

endpackage

// File: rtl/fbsram_seq.sv
module fbsram_seq
    import fbsram_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clk_en_n,
    input  logic          sel,
    input  logic          ld_n,
    input  logic          wr_n,
    input  logic          ilv_mode,
    input  logic [AW-1:0] addr,
    output burst_st_t     st,
    output logic [AW-1:0] cur_addr
);

    localparam int unsigned HW = AW - 2;

    burst_st_t     st_q, st_d;
    logic [HW-1:0] hi_q, hi_d;

    always_comb begin
        st_d = st_q;
        hi_d = hi_q;
        if (!clk_en_n) begin
            if (!ld_n) begin
                if (sel) begin
                    st_d.active = 1'b1;
                    st_d.dir    = wr_n ? DIR_RD : DIR_WR;
                    st_d.ilv    = ilv_mode;
                    st_d.start  = addr[1:0];
                    st_d.beat   = 2'd0;
                    hi_d        = addr[AW-1:2];
                end else begin
                    st_d.active = 1'b0;
                end
            end else if (st_q.active) begin
                st_d.beat = st_q.beat + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            hi_q <= '0;
        end else begin
            st_q <= st_d;
            hi_q <= hi_d;
        end
    end

    assign st       = st_q;
    assign cur_addr = {hi_q, burst_lo(st_q.start, st_q.beat, st_q.ilv)};

    a_r1_freeze: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |=> ($stable(st_q) && $stable(hi_q)));

    a_r2_load: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !ld_n && sel) |=>
            (st_q.active && st_q.beat == 2'd0 && cur_addr == $past(addr)
             && (st_q.dir == DIR_WR) == !$past(wr_n)));

    a_r6_advance: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ld_n && st_q.active) |=>
            (st_q.active && st_q.dir == $past(st_q.dir)
             && st_q.beat == $past(st_q.beat) + 2'd1));

    a_r9_idle_adv: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && ld_n && !st_q.active) |=> !st_q.active);

endmodule

// File: rtl/fbsram_array.sv
module fbsram_array
    import fbsram_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned NB = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [AW-1:0]        wr_addr,
    input  logic [NB-1:0]        wr_lanes,
    input  logic [NB*LANE_W-1:0] wr_data,
    input  logic [AW-1:0]        rd_addr,
    output logic [NB*LANE_W-1:0] rd_data
);

    localparam int unsigned DEPTH = 1 << AW;

    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (wr_en && wr_lanes[g]) begin
                mem[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        assign rd_data[g*LANE_W +: LANE_W] = mem[rd_addr];
    end

endmodule

// File: rtl/fbsram_top.sv
module fbsram_top
    import fbsram_pkg::*;
#(
    parameter int unsigned AW = 6,
    parameter int unsigned NB = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clk_en_n,
    input  logic                 cs1_n,
    input  logic                 cs2,
    input  logic                 cs3_n,
    input  logic                 ld_n,
    input  logic                 wr_n,
    input  logic [NB-1:0]        lane_n,
    input  logic                 ilv_mode,
    input  logic                 oe_n,
    input  logic [AW-1:0]        addr,
    input  logic [NB*LANE_W-1:0] din,
    output logic [NB*LANE_W-1:0] dout,
    output logic                 dout_vld
);

    localparam int unsigned DW = NB * LANE_W;

    logic          sel;
    burst_st_t     st;
    logic [AW-1:0] cur_addr;
    logic          wr_en;
    logic [DW-1:0] rd_data;

    assign sel = !cs1_n && cs2 && !cs3_n;

    fbsram_seq #(.AW(AW)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .clk_en_n (clk_en_n),
        .sel      (sel),
        .ld_n     (ld_n),
        .wr_n     (wr_n),
        .ilv_mode (ilv_mode),
        .addr     (addr),
        .st       (st),
        .cur_addr (cur_addr)
    );

    // write data belongs to the beat registered at the previous enabled edge
    assign wr_en = !clk_en_n && st.active && (st.dir == DIR_WR);

    fbsram_array #(.AW(AW), .NB(NB)) u_arr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (cur_addr),
        .wr_lanes (~lane_n),
        .wr_data  (din),
        .rd_addr  (cur_addr),
        .rd_data  (rd_data)
    );

    assign dout_vld = st.active && (st.dir == DIR_RD) && !oe_n;
    assign dout     = dout_vld ? rd_data : '0;

    a_r4_oe_gate: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dout_vld);

    a_r5_deselect: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && !ld_n && !sel) |=> !dout_vld);

    a_r11_reset: assert property (@(posedge clk)
        rst |=> !dout_vld);

endmodule

// File: tb/test_fbsram_top.sv
module test_fbsram_top;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = NB * 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          clk_en_n, cs1_n, cs2, cs3_n, ld_n, wr_n, ilv_mode, oe_n;
    logic [NB-1:0] lane_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic          dout_vld;

    int checks = 0;
    int fails  = 0;

    // reference model
    logic [DW-1:0] ref_mem [DEPTH];
    logic          m_act, m_wr, m_ilv;
    logic [AW-1:0] m_base;
    logic [1:0]    m_beat;

    always #2.5 clk = ~clk;

    fbsram_top #(.AW(AW), .NB(NB)) i_fbsram_top (
        .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .ld_n(ld_n), .wr_n(wr_n), .lane_n(lane_n),
        .ilv_mode(ilv_mode), .oe_n(oe_n), .addr(addr), .din(din),
        .dout(dout), .dout_vld(dout_vld)
    );

    function automatic logic [AW-1:0] m_cur();
        logic [1:0] lo;
        lo = m_ilv ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    task automatic compare(input string tag);
        logic exp_vld;
        string t;
        exp_vld = m_act && !m_wr && !oe_n;
        t = tag;
        if (t == "") t = (m_act && m_beat != 2'd0) ? (m_ilv ? "R8" : "R7") : "R4";
        checks++;
        if (dout_vld !== exp_vld) begin
            fails++;
            $display("FAIL %s: dout_vld=%0b expected %0b", (tag == "") ? "R5" : t,
                     dout_vld, exp_vld);
        end
        if (exp_vld) begin
            checks++;
            if (dout !== ref_mem[m_cur()]) begin
                fails++;
                $display("FAIL %s: dout=%h expected %h", t, dout, ref_mem[m_cur()]);
            end
        end
    endtask

    task automatic m_edge();
        if (!clk_en_n) begin
            if (m_act && m_wr)
                for (int i = 0; i < NB; i++)
                    if (!lane_n[i]) ref_mem[m_cur()][i*8 +: 8] = din[i*8 +: 8];
            if (!ld_n) begin
                if (!cs1_n && cs2 && !cs3_n) begin
                    m_act = 1'b1; m_wr = !wr_n; m_ilv = ilv_mode;
                    m_base = addr; m_beat = 2'd0;
                end else begin
                    m_act = 1'b0;
                end
            end else if (m_act) begin
                m_beat = m_beat + 2'd1;
            end
        end
    endtask

    task automatic step(input logic cen, input logic [2:0] cs, input logic ld,
                        input logic we, input logic [NB-1:0] bw, input logic mode,
                        input logic oe, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input string tag);
        @(negedge clk);
        clk_en_n = cen; cs1_n = cs[2]; cs2 = cs[1]; cs3_n = cs[0];
        ld_n = ld; wr_n = we; lane_n = bw; ilv_mode = mode; oe_n = oe;
        addr = a; din = d;
        #1 compare(tag);
        @(posedge clk);
        m_edge();
    endtask

    localparam logic [2:0] SEL = 3'b010;
    localparam logic [2:0] OFF = 3'b110;

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        clk_en_n = 1'b0; cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; ld_n = 1'b0;
        wr_n = 1'b1; lane_n = '1; ilv_mode = 1'b0; oe_n = 1'b0; addr = '0; din = '0;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        m_act = 1'b0; m_wr = 1'b0; m_ilv = 1'b0; m_base = '0; m_beat = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R11");
        rst = 1'b0;

        // R2: single writes 8..11 back to back, then R10 read right behind
        step(0, SEL, 0, 0, 4'h0, 0, 0, 6'd8,  32'h0, "R2");
        step(0, SEL, 0, 0, 4'h0, 0, 0, 6'd9,  32'h1111_0008, "R2");
        step(0, SEL, 0, 0, 4'h0, 0, 0, 6'd10, 32'h2222_0009, "R2");
        step(0, SEL, 0, 0, 4'h0, 0, 0, 6'd11, 32'h3333_000A, "R2");
        step(0, SEL, 0, 1, 4'h0, 0, 0, 6'd11, 32'h4444_000B, "R10");
        step(0, SEL, 0, 1, 4'h0, 0, 0, 6'd9,  32'h0, "R10");
        // R7: linear burst from start 1
        step(0, SEL, 1, 1, 4'hF, 0, 0, 6'd0, 32'h0, "R7");
        step(0, SEL, 1, 1, 4'hF, 0, 0, 6'd0, 32'h0, "R7");
        step(0, SEL, 1, 1, 4'hF, 0, 0, 6'd0, 32'h0, "R7");
        // R8: interleaved burst from start 2
        step(0, SEL, 0, 1, 4'hF, 1, 0, 6'd10, 32'h0, "R8");
        step(0, SEL, 1, 1, 4'hF, 0, 0, 6'd0, 32'h0, "R8");
        // R1: stall mid burst
        step(1, OFF, 0, 0, 4'h0, 0, 0, 6'd3, 32'hDEAD_BEEF, "R8");
        step(1, OFF, 0, 0, 4'h0, 0, 0, 6'd3, 32'hDEAD_BEEF, "R1");
        step(0, OFF, 1, 0, 4'h0, 0, 0, 6'd3, 32'h0, "R1");
        // R6: advance with selects off and write-enable low keeps reading
        step(0, OFF, 1, 0, 4'h0, 0, 0, 6'd3, 32'h0, "R6");
        step(0, SEL, 1, 1, 4'hF, 0, 1, 6'd3, 32'h0, "R6");
        step(0, SEL, 1, 1, 4'hF, 0, 1, 6'd3, 32'h0, "R4");
        // R5 deselect, then R9 advances are ignored
        step(0, OFF, 0, 1, 4'hF, 0, 0, 6'd0, 32'h0, "R6");
        step(0, SEL, 1, 1, 4'hF, 0, 0, 6'd0, 32'h0, "R5");
        step(0, SEL, 1, 1, 4'hF, 0, 0, 6'd0, 32'h0, "R9");
        step(0, SEL, 1, 0, 4'h0, 0, 0, 6'd0, 32'h0, "R9");
        // R3: partial write, with a stall at the data edge
        step(0, SEL, 0, 0, 4'h0, 0, 0, 6'd9, 32'h0, "R9");
        step(1, SEL, 0, 1, 4'h0, 0, 0, 6'd9, 32'hFFFF_FFFF, "R1");
        step(0, SEL, 0, 1, 4'b1010, 0, 0, 6'd9, 32'hA5B6_C7D8, "R3");
        step(0, SEL, 1, 1, 4'hF, 0, 0, 6'd9, 32'h0, "R3");
        step(0, SEL, 1, 1, 4'hF, 0, 0, 6'd9, 32'h0, "R3");

        // constrained random mix
        for (int n = 0; n < 4000; n++) begin
            logic          cen, ld, we, mode, oe;
            logic [2:0]    cs;
            logic [NB-1:0] bw;
            cen  = ($urandom % 8) == 0;
            cs   = (($urandom % 7) == 0) ? 3'($urandom) : SEL;
            ld   = ($urandom % 3) != 0;
            we   = $urandom % 2;
            bw   = (($urandom % 3) == 0) ? NB'($urandom) : '0;
            mode = $urandom % 2;
            oe   = ($urandom % 10) == 0;
            step(cen, cs, ld, we, bw, mode, oe, AW'($urandom), $urandom, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule